// File: doc/BRIEF.md
# Instruction Fetch Bus Master

This block sits between an instruction cache and a 64-bit local bus and performs read-only refills on the cache's behalf. When the cache reports a miss, or an access to memory that must not be cached, the block latches the fetch address and attributes and raises a bus request. The request carries a word address (the upper 30 bits of the 32-bit fetch address, forced to doubleword alignment), a two-bit size code and the cacheability and user attributes.

Once the bus acknowledges the address, the block drops the request and counts read-data beats. The number of beats depends on the transfer size and on whether the attached bus is 64 or 32 bits wide, selected per fetch by a strap input. Each beat is passed back to the cache one cycle after it arrives, and the last one carries a completion pulse. Only one fetch is outstanding at a time.

Top module: `ifm_fetch_master`

## Requirements
- R1: A fetch is accepted only when `fetch_ready_o` is high, `fetch_valid_i` is high and either `fetch_miss_i` is high or `fetch_cacheable_i` is low; a valid cacheable hit raises no bus request and leaves `fetch_ready_o` high.
- R2: `bus_addr_o` equals bits 31 down to 3 of the accepted fetch address with a zero appended as its lowest bit, so the word address is always doubleword aligned.
- R3: `bus_size_o` is 2'b10 (eight words) for every cacheable fetch; a non-cacheable fetch uses 2'b01 (four words) when `fetch_quad_i` is high and 2'b10 otherwise.
- R4: `bus_cacheable_o` and `bus_user_o` carry the accepted fetch's cacheable and user attributes for the whole request.
- R5: `bus_req_o` rises in the cycle after acceptance; request, address, size and attributes stay unchanged until `bus_addr_ack_i` is sampled high, and `bus_req_o` is low in the following cycle.
- R6: After the address acknowledge, the block takes one beat per cycle in which `bus_rd_ack_i` is high: 2 or 4 beats (four or eight words) when `bus32_i` was low at acceptance, 4 or 8 beats when it was high. Each beat appears on `rsp_valid_o`/`rsp_data_o` in the next cycle; `bus_rd_ack_i` before the address acknowledge or while idle produces no response.
- R7: `rsp_last_o` is high for exactly one cycle, together with the response of the final beat, and `fetch_ready_o` is high in that same cycle.
- R8: From acceptance until the final beat, `fetch_ready_o` is low and new fetch inputs do not alter the outstanding request.
- R9: A synchronous active-high `rst` returns the block to idle: `bus_req_o`, `rsp_valid_o` and `rsp_last_o` low and `fetch_ready_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus32_i | input | 1 | Attached bus is 32 bits wide (sampled at acceptance) |
| fetch_valid_i | input | 1 | Cache presents a fetch |
| fetch_ready_o | output | 1 | Block is idle and can accept a fetch |
| fetch_miss_i | input | 1 | Access missed the cache |
| fetch_addr_i | input | 32 | Byte address of the fetch |
| fetch_cacheable_i | input | 1 | Target is cacheable |
| fetch_user_i | input | 1 | User-defined storage attribute |
| fetch_quad_i | input | 1 | Non-cacheable fetch wants four words |
| bus_req_o | output | 1 | Bus read request |
| bus_addr_o | output | 30 | Word address, doubleword aligned |
| bus_size_o | output | 2 | 2'b01 four words, 2'b10 eight words |
| bus_cacheable_o | output | 1 | Cacheable attribute of the request |
| bus_user_o | output | 1 | User attribute of the request |
| bus_addr_ack_i | input | 1 | Bus accepted the address |
| bus_rd_ack_i | input | 1 | Read data beat valid |
| bus_rd_data_i | input | 64 | Read data |
| rsp_valid_o | output | 1 | Beat returned to the cache |
| rsp_data_o | output | 64 | Returned data |
| rsp_last_o | output | 1 | Final beat of the fetch |

## Verification
A corrupt state register shows within one cycle, as a request that fails to drop after its acknowledge, a `fetch_ready_o` that is high while a request is pending, or a response with no matching bus beat. A wrong beat counter or beat target shows at the end of the fetch, as `rsp_last_o` on the wrong beat, or as a block that stays busy and never accepts the next fetch. Latched attributes that are wrong are visible on the bus outputs in the first cycle of the request.

// File: rtl/ifm_pkg.sv
package ifm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } ifm_state_e;

  localparam logic [1:0] SZ_QUAD = 2'b01;
  localparam logic [1:0] SZ_LINE = 2'b10;
endpackage

// File: rtl/ifm_req_ctrl.sv
module ifm_req_ctrl
  import ifm_pkg::*;
#(
  parameter int FETCH_AW   = 32,
  parameter int BUS_AW     = FETCH_AW - 2,
  parameter int QUAD_WORDS = 4,
  parameter int LINE_WORDS = 8,
  parameter int CNT_W      = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus32_i,
  input  logic                fetch_valid_i,
  input  logic                fetch_miss_i,
  input  logic [FETCH_AW-1:0] fetch_addr_i,
  input  logic                fetch_cacheable_i,
  input  logic                fetch_user_i,
  input  logic                fetch_quad_i,
  input  logic                bus_addr_ack_i,
  input  logic                final_beat_i,
  output logic                fetch_ready_o,
  output logic                bus_req_o,
  output logic [BUS_AW-1:0]   bus_addr_o,
  output logic [1:0]          bus_size_o,
  output logic                bus_cacheable_o,
  output logic                bus_user_o,
  output logic                data_phase_o,
  output logic [CNT_W-1:0]    beat_target_o
);
  ifm_state_e state_q;
  logic       accept;
  logic       use_quad;
  logic [CNT_W-1:0] words;
  logic [CNT_W-1:0] beats;
  logic [2:0] unused_low;

  assign unused_low = fetch_addr_i[2:0];

  // A cacheable hit needs no refill; everything else that is valid goes out.
  assign accept   = (state_q == ST_IDLE) && fetch_valid_i &&
                    (fetch_miss_i || !fetch_cacheable_i);
  // Cacheable fetches always fill a whole line.
  assign use_quad = !fetch_cacheable_i && fetch_quad_i;
  assign words    = use_quad ? CNT_W'(QUAD_WORDS) : CNT_W'(LINE_WORDS);
  // One word per beat on the narrow bus, two on the wide one.
  assign beats    = bus32_i ? words : (words >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q         <= ST_IDLE;
      bus_req_o       <= 1'b0;
      bus_addr_o      <= '0;
      bus_size_o      <= '0;
      bus_cacheable_o <= 1'b0;
      bus_user_o      <= 1'b0;
      beat_target_o   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q         <= ST_ADDR;
            bus_req_o       <= 1'b1;
            bus_addr_o      <= {fetch_addr_i[FETCH_AW-1:3], 1'b0};
            bus_size_o      <= use_quad ? SZ_QUAD : SZ_LINE;
            bus_cacheable_o <= fetch_cacheable_i;
            bus_user_o      <= fetch_user_i;
            beat_target_o   <= beats;
          end
        end
        ST_ADDR: begin
          if (bus_addr_ack_i) begin
            state_q   <= ST_DATA;
            bus_req_o <= 1'b0;
          end
        end
        ST_DATA: begin
          if (final_beat_i) begin
            state_q <= ST_IDLE;
          end
        end
        default: begin
          state_q   <= ST_IDLE;
          bus_req_o <= 1'b0;
        end
      endcase
    end
  end

  assign fetch_ready_o = (state_q == ST_IDLE);
  assign data_phase_o  = (state_q == ST_DATA);
endmodule

// File: rtl/ifm_beat_cnt.sv
module ifm_beat_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             data_phase_i,
  input  logic             rd_ack_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             beat_o,
  output logic             final_beat_o
);
  logic [CNT_W-1:0] cnt_q;

  // Beats are only meaningful once the address phase has completed.
  assign beat_o       = data_phase_i && rd_ack_i;
  assign final_beat_o = beat_o && (cnt_q == target_i - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !data_phase_i) begin
      cnt_q <= '0;
    end else if (final_beat_o) begin
      cnt_q <= '0;
    end else if (beat_o) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/ifm_rsp_path.sv
module ifm_rsp_path #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_i,
  input  logic              final_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              rsp_valid_o,
  output logic              rsp_last_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_last_o  <= 1'b0;
    end else begin
      rsp_valid_o <= beat_i;
      rsp_last_o  <= final_i;
    end
  end

  // Data register carries no reset so it maps onto plain flops.
  always_ff @(posedge clk) begin
    if (beat_i) begin
      rsp_data_o <= data_i;
    end
  end
endmodule

// File: rtl/ifm_fetch_master.sv
module ifm_fetch_master #(
  parameter int FETCH_AW   = 32,
  parameter int DATA_W     = 64,
  parameter int QUAD_WORDS = 4,
  parameter int LINE_WORDS = 8,
  localparam int BUS_AW    = FETCH_AW - 2,
  localparam int CNT_W     = $clog2(LINE_WORDS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus32_i,
  input  logic                fetch_valid_i,
  output logic                fetch_ready_o,
  input  logic                fetch_miss_i,
  input  logic [FETCH_AW-1:0] fetch_addr_i,
  input  logic                fetch_cacheable_i,
  input  logic                fetch_user_i,
  input  logic                fetch_quad_i,
  output logic                bus_req_o,
  output logic [BUS_AW-1:0]   bus_addr_o,
  output logic [1:0]          bus_size_o,
  output logic                bus_cacheable_o,
  output logic                bus_user_o,
  input  logic                bus_addr_ack_i,
  input  logic                bus_rd_ack_i,
  input  logic [DATA_W-1:0]   bus_rd_data_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_data_o,
  output logic                rsp_last_o
);
  logic             data_phase;
  logic             beat;
  logic             final_beat;
  logic [CNT_W-1:0] beat_target;

  ifm_req_ctrl #(
    .FETCH_AW  (FETCH_AW),
    .BUS_AW    (BUS_AW),
    .QUAD_WORDS(QUAD_WORDS),
    .LINE_WORDS(LINE_WORDS),
    .CNT_W     (CNT_W)
  ) ctrl_i (
    .clk              (clk),
    .rst              (rst),
    .bus32_i          (bus32_i),
    .fetch_valid_i    (fetch_valid_i),
    .fetch_miss_i     (fetch_miss_i),
    .fetch_addr_i     (fetch_addr_i),
    .fetch_cacheable_i(fetch_cacheable_i),
    .fetch_user_i     (fetch_user_i),
    .fetch_quad_i     (fetch_quad_i),
    .bus_addr_ack_i   (bus_addr_ack_i),
    .final_beat_i     (final_beat),
    .fetch_ready_o    (fetch_ready_o),
    .bus_req_o        (bus_req_o),
    .bus_addr_o       (bus_addr_o),
    .bus_size_o       (bus_size_o),
    .bus_cacheable_o  (bus_cacheable_o),
    .bus_user_o       (bus_user_o),
    .data_phase_o     (data_phase),
    .beat_target_o    (beat_target)
  );

  ifm_beat_cnt #(
    .CNT_W(CNT_W)
  ) cnt_i (
    .clk         (clk),
    .rst         (rst),
    .data_phase_i(data_phase),
    .rd_ack_i    (bus_rd_ack_i),
    .target_i    (beat_target),
    .beat_o      (beat),
    .final_beat_o(final_beat)
  );

  ifm_rsp_path #(
    .DATA_W(DATA_W)
  ) rsp_i (
    .clk        (clk),
    .rst        (rst),
    .beat_i     (beat),
    .final_i    (final_beat),
    .data_i     (bus_rd_data_i),
    .rsp_valid_o(rsp_valid_o),
    .rsp_last_o (rsp_last_o),
    .rsp_data_o (rsp_data_o)
  );
endmodule

// File: rtl/ifm_fetch_master_chk.sv
module ifm_fetch_master_chk #(
  parameter int BUS_AW = 30
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_ready_o,
  input logic              bus_req_o,
  input logic [BUS_AW-1:0] bus_addr_o,
  input logic [1:0]        bus_size_o,
  input logic              bus_cacheable_o,
  input logic              bus_user_o,
  input logic              bus_addr_ack_i,
  input logic              rsp_valid_o,
  input logic              rsp_last_o
);
  p_align_r2: assert property (@(posedge clk) disable iff (rst)
    bus_req_o |-> (bus_addr_o[0] == 1'b0));

  p_line_when_cacheable_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_req_o && bus_cacheable_o) |-> (bus_size_o == 2'b10));

  p_size_legal_r3: assert property (@(posedge clk) disable iff (rst)
    bus_req_o |-> (bus_size_o == 2'b01 || bus_size_o == 2'b10));

  p_hold_until_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_req_o && !bus_addr_ack_i) |=> (bus_req_o && $stable(bus_addr_o) &&
      $stable(bus_size_o) && $stable(bus_cacheable_o) && $stable(bus_user_o)));

  p_drop_after_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_req_o && bus_addr_ack_i) |=> !bus_req_o);

  p_last_with_valid_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_last_o |-> (rsp_valid_o && fetch_ready_o));

  p_last_single_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_last_o |=> !rsp_last_o);

  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
    bus_req_o |-> !fetch_ready_o);

  p_reset_idle_r9: assert property (@(posedge clk)
    rst |=> (!bus_req_o && !rsp_valid_o && !rsp_last_o && fetch_ready_o));
endmodule

bind ifm_fetch_master ifm_fetch_master_chk #(.BUS_AW(BUS_AW)) chk_i (.*);

// File: tb/ifm_fetch_master_tb_top.sv
module ifm_fetch_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus32_i = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic        fetch_ready_o;
  logic        fetch_miss_i = 1'b0;
  logic [31:0] fetch_addr_i = '0;
  logic        fetch_cacheable_i = 1'b0;
  logic        fetch_user_i = 1'b0;
  logic        fetch_quad_i = 1'b0;
  logic        bus_req_o;
  logic [29:0] bus_addr_o;
  logic [1:0]  bus_size_o;
  logic        bus_cacheable_o;
  logic        bus_user_o;
  logic        bus_addr_ack_i = 1'b0;
  logic        bus_rd_ack_i = 1'b0;
  logic [63:0] bus_rd_data_i = '0;
  logic        rsp_valid_o;
  logic [63:0] rsp_data_o;
  logic        rsp_last_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;
  logic [64:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ifm_fetch_master dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: every returned beat must match the oldest expected one.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rsp_valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected response", rsp_data_o, 64'h0);
        end else begin
          logic [64:0] e;
          e = exp_q.pop_front();
          check(rsp_data_o == e[63:0], "R6 data", rsp_data_o, e[63:0]);
          check(rsp_last_o == e[64], "R7 last flag", 64'(rsp_last_o), 64'(e[64]));
        end
      end else if (!rst && rsp_last_o) begin
        check(1'b0, "R7 last without valid", 64'(rsp_last_o), 64'h0);
      end
    end
  end

  task automatic do_fetch(input logic [31:0] addr, input bit cach, input bit miss,
                          input bit quad, input bit user, input bit b32,
                          input int ack_dly, input bit gaps, input bit poke);
    int words;
    int nb;
    logic [29:0] exp_addr;
    logic [1:0]  exp_size;
    words    = (cach || !quad) ? 8 : 4;
    nb       = b32 ? words : words / 2;
    exp_addr = {addr[31:3], 1'b0};
    exp_size = (words == 8) ? 2'b10 : 2'b01;
    @(negedge clk);
    check(fetch_ready_o == 1'b1, "R7 ready before fetch", 64'(fetch_ready_o), 64'h1);
    fetch_valid_i = 1'b1; fetch_addr_i = addr; fetch_cacheable_i = cach;
    fetch_miss_i = miss; fetch_quad_i = quad; fetch_user_i = user; bus32_i = b32;
    @(negedge clk);
    fetch_valid_i = 1'b0; bus32_i = ~b32;
    check(bus_req_o == 1'b1, "R1 request raised", 64'(bus_req_o), 64'h1);
    check(bus_addr_o == exp_addr, "R2 address", 64'(bus_addr_o), 64'(exp_addr));
    check(bus_size_o == exp_size, "R3 size", 64'(bus_size_o), 64'(exp_size));
    check({bus_cacheable_o, bus_user_o} == {cach, user}, "R4 attributes",
          64'({bus_cacheable_o, bus_user_o}), 64'({cach, user}));
    check(fetch_ready_o == 1'b0, "R8 busy", 64'(fetch_ready_o), 64'h0);
    for (int i = 0; i < ack_dly; i++) begin
      if (poke) begin
        fetch_valid_i = 1'b1; fetch_miss_i = 1'b1; fetch_cacheable_i = ~cach;
        fetch_addr_i = ~addr; fetch_quad_i = ~quad; fetch_user_i = ~user;
        bus_rd_ack_i = 1'b1; bus_rd_data_i = 64'hDEAD_BEEF_0BAD_F00D;
      end
      @(negedge clk);
      check(bus_req_o == 1'b1 && bus_addr_o == exp_addr && bus_size_o == exp_size &&
            bus_user_o == user, "R5 held until ack R8",
            64'({bus_req_o, bus_addr_o}), 64'({1'b1, exp_addr}));
    end
    fetch_valid_i = 1'b0; bus_rd_ack_i = 1'b0;
    bus_addr_ack_i = 1'b1;
    @(negedge clk);
    bus_addr_ack_i = 1'b0;
    check(bus_req_o == 1'b0, "R5 drop after ack", 64'(bus_req_o), 64'h0);
    for (int b = 0; b < nb; b++) begin
      if (gaps && (b % 2 == 1)) @(negedge clk);
      bus_rd_ack_i  = 1'b1;
      bus_rd_data_i = {addr, 32'(b) * 32'h0101_0101 ^ 32'hA5A5_0000};
      exp_q.push_back({(b == nb - 1), bus_rd_data_i});
      @(negedge clk);
      bus_rd_ack_i = 1'b0;
    end
    check(fetch_ready_o == 1'b1, "R7 ready with last beat", 64'(fetch_ready_o), 64'h1);
    check(rsp_last_o == 1'b1, "R6 beat count reaches last", 64'(rsp_last_o), 64'h1);
    @(negedge clk);
    check(rsp_last_o == 1'b0, "R7 single-cycle last", 64'(rsp_last_o), 64'h0);
    check(exp_q.size() == 0, "R6 all beats returned", 64'(exp_q.size()), 64'h0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(1'b0, "watchdog", 64'h0, 64'h1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!bus_req_o && !rsp_valid_o && !rsp_last_o && fetch_ready_o, "R9 reset state",
          64'({bus_req_o, rsp_valid_o, rsp_last_o, fetch_ready_o}), 64'h1);
    rst = 1'b0;

    // R3 R6: cacheable miss, wide bus, eight words in four beats
    do_fetch(32'h0000_1234, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0);
    // R3 R6: non-cacheable four words, wide bus, delayed ack
    do_fetch(32'h8000_0F0C, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3, 1'b0, 1'b0);
    // R3: non-cacheable without quad request is a line
    do_fetch(32'h4000_0004, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1, 1'b1, 1'b0);
    // R3: cacheable ignores quad request
    do_fetch(32'hFFFF_FFFC, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 0, 1'b0, 1'b0);
    // R6: narrow bus four and eight beats, with gaps
    do_fetch(32'h1234_5678, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2, 1'b1, 1'b0);
    do_fetch(32'h0BAD_CAFE, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 0, 1'b1, 1'b0);
    // R8 R6: inputs change and stray data acks while waiting for address ack
    do_fetch(32'h2000_0040, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4, 1'b0, 1'b1);

    // R1: cacheable hit must not start a request
    @(negedge clk);
    fetch_valid_i = 1'b1; fetch_cacheable_i = 1'b1; fetch_miss_i = 1'b0;
    fetch_addr_i = 32'h3000_0000;
    @(negedge clk);
    fetch_valid_i = 1'b0;
    check(bus_req_o == 1'b0 && fetch_ready_o == 1'b1, "R1 cacheable hit ignored",
          64'({bus_req_o, fetch_ready_o}), 64'h1);

    // R6: stray data ack while idle yields no response (monitor flags any)
    bus_rd_ack_i = 1'b1; bus_rd_data_i = 64'h1111_2222_3333_4444;
    @(negedge clk);
    bus_rd_ack_i = 1'b0;
    @(negedge clk);
    check(rsp_valid_o == 1'b0, "R6 idle data ack ignored", 64'(rsp_valid_o), 64'h0);

    // R9: reset in the middle of a request returns to idle
    @(negedge clk);
    fetch_valid_i = 1'b1; fetch_miss_i = 1'b1;
    @(negedge clk);
    fetch_valid_i = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!bus_req_o && fetch_ready_o, "R9 mid-request reset",
          64'({bus_req_o, fetch_ready_o}), 64'h1);

    // R1: normal fetch after reset still works
    do_fetch(32'h0000_0008, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule